// File: doc/BRIEF.md
# Steered Interrupt Controller

The block gathers a word of level-sensitive interrupt sources, passes each through a synchronising register chain, and shows the result as a raw pending word. Two software-visible registers decide where each source goes. The enable register lets a source through only where its bit is set. The steering register then sends each enabled source to one of two outputs: the normal interrupt line `irq` or the fast interrupt line `fiq`.

Software uses a simple word-indexed register port: a write strobe, a 4-bit word index, and 32-bit write and read data. Reads are combinational from the current state. Separate words show the sources steered to each output after masking, so a handler can see what raised its own line. A source is cleared only at the peripheral that raised it. The controller never stores an interrupt.

Top module: `intc_steer`

## Requirements
- R1: While and after reset, the enable and steering registers hold all zeros, and both `irq` and `fiq` are low.
- R2: The raw pending word (word index 8, byte offset 0x20) shows each source input two clock edges after the input is sampled, whatever the enable register holds.
- R3: Source position 14 is unused: bit 14 reads 0 in the raw, IRQ-pending and FIQ-pending words, and that source never raises either output.
- R4: A source whose enable bit is 0 appears in neither pending word and asserts neither output.
- R5: The IRQ-pending word (word index 0, offset 0x00) equals raw AND enable AND NOT steering, so a steering bit of 0 selects the normal output.
- R6: The FIQ-pending word (word index 4, offset 0x10) equals raw AND enable AND steering, so a steering bit of 1 selects the fast output.
- R7: `irq` is the OR of all bits of the IRQ-pending word, and `fiq` is the OR of all bits of the FIQ-pending word, each delayed by one clock register.
- R8: A write to the enable register (word index 1, offset 0x04) or the steering register (word index 2, offset 0x08) takes effect at that clock edge and reads back the written 32-bit value.
- R9: Writes to the pending words (indices 0, 4, 8), the control word (index 3), reserved indices 5 to 7, and any index above 8 change no state. The control word and every reserved or unmapped index read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources, asynchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_word | input | 4 | Word index (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Normal interrupt request, active high |
| fiq | output | 1 | Fast interrupt request, active high |

## Verification
The bench builds the block with its default parameters: 32 sources, a two-stage synchroniser and position 14 as the unused slot. With these values every source bit, the gap at bit 14 and the full two-edge input latency can be checked against the byte offsets software would use. A pseudo-random source stream runs under several enable and steering settings, including all-normal, all-fast and disjoint mixes. This exercises both outputs together and each alone. The run also writes to every pending, control and reserved index, then reads each of them back through the read port.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 4;

    // Word indices of the register port. The positions are fixed by software.
    typedef enum logic [SEL_W-1:0] {
        SEL_IRQ_PEND = 4'd0,
        SEL_ENABLE   = 4'd1,
        SEL_STEER    = 4'd2,
        SEL_CTRL     = 4'd3,
        SEL_FIQ_PEND = 4'd4,
        SEL_RAW      = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] irq_word;
        logic [DATA_W-1:0] fiq_word;
    } pend_t;

    typedef struct packed {
        logic [DATA_W-1:0] enable;
        logic [DATA_W-1:0] steer;
    } cfg_t;

    // Mask of the source positions that exist, with the unused slot removed.
    function automatic logic [DATA_W-1:0] live_mask(input int n_src, input int hole);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < n_src) && (i != hole);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] to_irq(input logic [DATA_W-1:0] raw,
                                                 input cfg_t c);
        return raw & c.enable & ~c.steer;
    endfunction

    function automatic logic [DATA_W-1:0] to_fiq(input logic [DATA_W-1:0] raw,
                                                 input cfg_t c);
        return raw & c.enable & c.steer;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            // Only the two storage words accept writes.
            case (reg_sel_e'(sel))
                SEL_ENABLE: cfg_q.enable <= wdata;
                SEL_STEER:  cfg_q.steer  <= wdata;
                default:    ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int HOLE    = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] synced,
    input  cfg_t              cfg,
    output pend_t             pend,
    output logic              irq_q,
    output logic              fiq_q
);
    localparam logic [DATA_W-1:0] LIVE = live_mask(NUM_SRC, HOLE);

    always_comb begin
        pend.raw      = synced & LIVE;
        pend.irq_word = to_irq(pend.raw, cfg);
        pend.fiq_word = to_fiq(pend.raw, cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |pend.irq_word;
            fiq_q <= |pend.fiq_word;
        end
    end
endmodule

// File: rtl/intc_steer.sv
module intc_steer
    import intc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int HOLE        = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_word,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq,
    output logic               fiq
);
    logic [NUM_SRC-1:0] sync_w;
    logic [DATA_W-1:0]  synced_w;
    cfg_t               cfg_w;
    pend_t              pend_w;

    intc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_i),
        .q   (sync_w)
    );

    if (NUM_SRC < DATA_W) begin : g_pad
        assign synced_w = {{(DATA_W-NUM_SRC){1'b0}}, sync_w};
    end else begin : g_full
        assign synced_w = sync_w;
    end

    intc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (reg_word),
        .wdata (reg_wdata),
        .cfg   (cfg_w)
    );

    intc_route #(.NUM_SRC(NUM_SRC), .HOLE(HOLE)) u_route (
        .clk    (clk),
        .rst    (rst),
        .synced (synced_w),
        .cfg    (cfg_w),
        .pend   (pend_w),
        .irq_q  (irq),
        .fiq_q  (fiq)
    );

    always_comb begin
        case (reg_sel_e'(reg_word))
            SEL_IRQ_PEND: reg_rdata = pend_w.irq_word;
            SEL_ENABLE:   reg_rdata = cfg_w.enable;
            SEL_STEER:    reg_rdata = cfg_w.steer;
            SEL_FIQ_PEND: reg_rdata = pend_w.fiq_word;
            SEL_RAW:      reg_rdata = pend_w.raw;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [SEL_W-1:0]  reg_word,
    input logic              irq,
    input logic              fiq,
    input cfg_t              cfg,
    input pend_t             pend
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && !fiq && cfg == '0));

    // R3
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst) !pend.raw[14]);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable == '0) |=> (!irq && !fiq));

    // R6
    disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (pend.irq_word & pend.fiq_word) == '0);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (pend.irq_word != '0) |=> irq);

    // R7
    fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (pend.fiq_word == '0) |=> !fiq);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_word != SEL_ENABLE && reg_word != SEL_STEER) |=> $stable(cfg));
endmodule

bind intc_steer intc_steer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_word (reg_word),
    .irq      (irq),
    .fiq      (fiq),
    .cfg      (cfg_w),
    .pend     (pend_w)
);

// File: tb/intc_steer_bench.sv
module intc_steer_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HOLE_M = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [3:0]  word = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [31:0] m_s0 = '0, m_s1 = '0, m_en = '0, m_st = '0;
    logic        m_irq = 1'b0, m_fiq = 1'b0;

    intc_steer u_intc_steer (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .reg_wr    (wr),
        .reg_word  (word),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq       (irq),
        .fiq       (fiq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_raw();
        return m_s1 & ~HOLE_M;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s0 <= '0; m_s1 <= '0; m_en <= '0; m_st <= '0;
            m_irq <= 1'b0; m_fiq <= 1'b0;
        end else begin
            m_s0  <= src;
            m_s1  <= m_s0;
            m_irq <= |(m_raw() & m_en & ~m_st);
            m_fiq <= |(m_raw() & m_en & m_st);
            if (wr && word == 4'd1) m_en <= wdata;
            if (wr && word == 4'd2) m_st <= wdata;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] w);
        case (w)
            4'd0:    return m_raw() & m_en & ~m_st;
            4'd1:    return m_en;
            4'd2:    return m_st;
            4'd4:    return m_raw() & m_en & m_st;
            4'd8:    return m_raw();
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] w);
        case (w)
            4'd0:    return "R5";
            4'd4:    return "R6";
            4'd8:    return "R2";
            4'd1, 4'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 irq", {31'd0, irq}, {31'd0, m_irq});
            check("R7 fiq", {31'd0, fiq}, {31'd0, m_fiq});
            check(read_tag(word), rdata, m_read(word));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr_reg(input logic [3:0] w, input logic [31:0] d);
        wr = 1'b1; word = w; wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] w, output logic [31:0] d);
        word = w; #1; d = rdata;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] lfsr;
        lfsr = 32'h1357_9bdf;
        step(3);
        // R1: state under reset
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 fiq", {31'd0, fiq}, 32'd0);
        rst = 1'b0;
        peek(4'd1, v); check("R1 enable", v, 32'd0);
        peek(4'd2, v); check("R1 steer", v, 32'd0);

        // R4 and R3: all sources high, nothing enabled
        src = 32'hFFFF_FFFF;
        step(4);
        check("R4 irq", {31'd0, irq}, 32'd0);
        check("R4 fiq", {31'd0, fiq}, 32'd0);
        peek(4'd8, v); check("R3 raw", v, 32'hFFFF_BFFF);

        // R3: only the unused position is active, everything enabled
        wr_reg(4'd1, 32'hFFFF_FFFF);
        src = HOLE_M;
        step(4);
        check("R3 irq", {31'd0, irq}, 32'd0);
        peek(4'd0, v); check("R3 irq word", v, 32'd0);
        wr_reg(4'd2, 32'hFFFF_FFFF);
        step(2);
        check("R3 fiq", {31'd0, fiq}, 32'd0);
        peek(4'd4, v); check("R3 fiq word", v, 32'd0);

        // R2: raw latency of exactly two edges
        word = 4'd8;
        src = 32'h0000_0001;
        step(1);
        check("R2 one edge", rdata, 32'd0);
        step(1);
        check("R2 two edges", rdata, 32'h0000_0001);

        // R9: writes to pending, control, reserved and unmapped indices
        wr_reg(4'd1, 32'h0F0F_0F0F);
        wr_reg(4'd2, 32'h00FF_00FF);
        for (int w = 0; w < 16; w++) begin
            if (w != 1 && w != 2) wr_reg(4'(w), 32'hDEAD_BEEF);
        end
        peek(4'd1, v); check("R9 enable kept", v, 32'h0F0F_0F0F);
        peek(4'd2, v); check("R9 steer kept", v, 32'h00FF_00FF);
        peek(4'd3, v); check("R9 control", v, 32'd0);
        peek(4'd6, v); check("R9 reserved", v, 32'd0);

        // Random sources under several steering setups
        for (int phase = 0; phase < 4; phase++) begin
            case (phase)
                0: begin wr_reg(4'd1, 32'hFFFF_FFFF); wr_reg(4'd2, 32'h0000_0000); end
                1: begin wr_reg(4'd1, 32'hFFFF_FFFF); wr_reg(4'd2, 32'hFFFF_FFFF); end
                2: begin wr_reg(4'd1, 32'h3C00_0FFF); wr_reg(4'd2, 32'h3C00_0000); end
                default: begin wr_reg(4'd1, 32'h0000_0800); wr_reg(4'd2, 32'h8000_0000); end
            endcase
            for (int i = 0; i < 200; i++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                src  = (i % 3 == 0) ? (lfsr & (lfsr >> 7)) : ((i % 3 == 1) ? 32'd0 : lfsr);
                word = 4'((i % 5 == 4) ? 8 : (i % 5) * (i % 2 == 0 ? 1 : 4) % 9);
                step(1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule